// File: doc/BRIEF.md
# Banked In-Order Gather Memory

This block serves a stream of independent reads whose addresses follow no stride. A client presents one address per cycle on a valid/ready request port. The block fans the requests out over a set of interleaved storage banks. Each bank hides a long fixed access time behind its own pipeline. Returning words are put back into request order before they leave on a valid/ready response port. When requests land on distinct banks, one result emerges per cycle once the pipeline has filled. A request aimed at a bank that is still recovering from its previous access stalls at the request port, and only that request waits.

A programmable seed selects an XOR-fold hash that maps addresses to banks. The default seed of zero gives plain low-order interleaving. The storage is loaded through a simple write port while nothing is outstanding. A gather is a run of requests that ends with a request carrying the last flag. A one-cycle done pulse marks the moment the matching response has been taken.

Top module: `gather_mem`

## Requirements
- R1: After reset, rsp_valid and done are 0 and req_ready is 1.
- R2: A request accepted at clock edge E on an idle block makes rsp_valid rise after edge E+17, with the word stored at that address.
- R3: Requests to distinct banks are accepted on consecutive edges with no stall. With rsp_ready held high, their responses are taken on consecutive edges.
- R4: Responses leave in exactly the order the requests were accepted. Each carries the word held at its address.
- R5: A bank that accepted a request at edge E accepts no other before edge E+4. While the addressed bank is in that interval, req_ready is 0.
- R6: The bank index is addr[3:0] XOR addr[7:4]&seed[3:0] XOR {2'b00, addr[9:8]&seed[5:4]}, where the 6-bit seed masks the row bits addr[9:4]. A seed of 0 uses addr[3:0] alone.
- R7: Seed writes and load-port writes take effect only while no request is outstanding. At other times they are ignored.
- R8: While rsp_valid is 1 and rsp_ready is 0, rsp_data holds steady and no result is lost.
- R9: At most 64 requests are outstanding, counting accepted requests whose responses have not been taken. At 64, req_ready is 0 until a response is taken.
- R10: done is high for exactly one cycle, in the cycle after the edge at which the response of a request flagged req_last is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_seed_we | input | 1 | Seed write strobe |
| cfg_seed | input | 6 | Hash seed value |
| load_en | input | 1 | Storage load strobe |
| load_addr | input | 10 | Word address to load |
| load_data | input | 16 | Word to load |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this edge if valid |
| req_addr | input | 10 | Word address to read |
| req_last | input | 1 | Final request of a gather |
| rsp_valid | output | 1 | In-order result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_data | output | 16 | Result word |
| done | output | 1 | Last response of a gather was taken |

## Verification
The hardest state to reach from the ports is a reorder buffer holding all 64 tags while requests keep arriving. The bench holds rsp_ready low, streams 64 requests across rotating banks, and then keeps a 65th request waiting for many cycles before it releases the output. The hash seed can only be seen through timing. The bench picks address pairs that collide under one seed and not under another, and measures the spacing between acceptance edges. It also tries seed and load writes while a result is parked in the buffer.

// File: rtl/gather_pkg.sv
// Shared defaults for the gather memory pipeline.
// Assumes: all modules take their widths as parameters; these are only defaults.
package gather_pkg;
    localparam int unsigned GM_ADDR_W = 10;
    localparam int unsigned GM_DATA_W = 16;
    localparam int unsigned GM_NBANK  = 16;
    localparam int unsigned GM_LAT    = 17;
    localparam int unsigned GM_BUSY   = 4;
    localparam int unsigned GM_TAG_W  = 6;
endpackage

// File: rtl/gather_hash.sv
// Maps a word address to a bank index and a row inside that bank.
// Bank = low address bits XOR the seed-masked row bits folded in bank-wide chunks.
// Assumes: ADDR_W > BANK_W; the row is the upper address bits, so the map is a bijection.
module gather_hash #(
    parameter int unsigned ADDR_W = gather_pkg::GM_ADDR_W,
    parameter int unsigned BANK_W = 4
) (
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [ADDR_W-BANK_W-1:0] seed_i,
    output logic [BANK_W-1:0]        bank_o,
    output logic [ADDR_W-BANK_W-1:0] row_o
);
    localparam int unsigned ROW_W  = ADDR_W - BANK_W;
    localparam int unsigned NCHUNK = (ROW_W + BANK_W - 1) / BANK_W;
    localparam int unsigned PAD_W  = NCHUNK * BANK_W;

    logic [PAD_W-1:0] spread;

    assign row_o  = addr_i[ADDR_W-1:BANK_W];
    assign spread = PAD_W'(row_o & seed_i);

    // Fold the masked row bits onto the low-order bank bits.
    always_comb begin
        bank_o = addr_i[BANK_W-1:0];
        for (int j = 0; j < NCHUNK; j++) begin
            bank_o = bank_o ^ spread[j*BANK_W +: BANK_W];
        end
    end
endmodule

// File: rtl/gather_bank.sv
// One storage bank with a fixed-latency read pipeline and a recovery interval.
// The word is read at the accept edge and carried with its tag through LAT stages.
// Assumes: the caller never asserts acc_i while busy_o is high; LAT >= 2; BUSY >= 2.
module gather_bank #(
    parameter int unsigned ROW_W  = 6,
    parameter int unsigned DATA_W = gather_pkg::GM_DATA_W,
    parameter int unsigned TAG_W  = gather_pkg::GM_TAG_W,
    parameter int unsigned LAT    = gather_pkg::GM_LAT,
    parameter int unsigned BUSY   = gather_pkg::GM_BUSY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic [TAG_W-1:0]  tag_i,
    input  logic              wr_i,
    input  logic [ROW_W-1:0]  wr_row_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              busy_o,
    output logic              ret_o,
    output logic [TAG_W-1:0]  ret_tag_o,
    output logic [DATA_W-1:0] ret_data_o
);
    localparam int unsigned ROWS   = 1 << ROW_W;
    localparam int unsigned BUSY_W = $clog2(BUSY + 1);

    logic [DATA_W-1:0] mem_q [ROWS];
    logic [LAT-1:0]    vld_q;
    logic [TAG_W-1:0]  tag_q [LAT];
    logic [DATA_W-1:0] dat_q [LAT];
    logic [BUSY_W-1:0] busy_q;
    logic [BUSY_W-1:0] since_q;

    // Storage array written through the load port.
    always_ff @(posedge clk) begin
        if (wr_i) mem_q[wr_row_i] <= wr_data_i;
    end

    // Valid bits of the access pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= {vld_q[LAT-2:0], acc_i};
    end

    // Tag and data stages; stage 0 captures the array read.
    always_ff @(posedge clk) begin
        tag_q[0] <= tag_i;
        dat_q[0] <= mem_q[row_i];
        for (int k = 1; k < LAT; k++) begin
            tag_q[k] <= tag_q[k-1];
            dat_q[k] <= dat_q[k-1];
        end
    end

    // Recovery countdown after each accepted access.
    always_ff @(posedge clk) begin
        if (!rst_n)              busy_q <= '0;
        else if (acc_i)          busy_q <= BUSY_W'(BUSY - 1);
        else if (busy_q != '0)   busy_q <= busy_q - 1'b1;
    end

    assign busy_o     = (busy_q != '0);
    assign ret_o      = vld_q[LAT-1];
    assign ret_tag_o  = tag_q[LAT-1];
    assign ret_data_o = dat_q[LAT-1];

    // Independent cycle count since the last accept, saturating, for the check below.
    always_ff @(posedge clk) begin
        if (!rst_n)                   since_q <= BUSY_W'(BUSY);
        else if (acc_i)               since_q <= BUSY_W'(1);
        else if (since_q < BUSY_W'(BUSY)) since_q <= since_q + 1'b1;
    end

    // R5: accepts on one bank are at least BUSY edges apart.
    assert_bank_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_i |-> since_q >= BUSY_W'(BUSY));
endmodule

// File: rtl/gather_rob.sv
// Reorder buffer indexed by issue tag; releases entries strictly in tag order.
// Tags are handed out sequentially at issue; returns may arrive in any order.
// Assumes: issue_i is never raised while full_o is high; one fill per cycle at most.
module gather_rob #(
    parameter int unsigned DATA_W = gather_pkg::GM_DATA_W,
    parameter int unsigned TAG_W  = gather_pkg::GM_TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic              issue_last_i,
    output logic [TAG_W-1:0]  issue_tag_o,
    output logic              full_o,
    output logic              empty_o,
    input  logic              fill_i,
    input  logic [TAG_W-1:0]  fill_tag_i,
    input  logic [DATA_W-1:0] fill_data_i,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] out_data_o,
    output logic              out_last_o,
    input  logic              out_ready_i
);
    localparam int unsigned DEPTH = 1 << TAG_W;

    logic [TAG_W-1:0]  head_q, tail_q;
    logic [TAG_W:0]    count_q;
    logic [DEPTH-1:0]  present_q;
    logic [DEPTH-1:0]  last_q;
    logic [DATA_W-1:0] data_q [DEPTH];
    logic              pop;

    assign pop         = out_valid_o && out_ready_i;
    assign issue_tag_o = tail_q;
    assign full_o      = (count_q == (TAG_W+1)'(DEPTH));
    assign empty_o     = (count_q == '0);
    assign out_valid_o = present_q[head_q];
    assign out_data_o  = data_q[head_q];
    assign out_last_o  = last_q[head_q];

    // Issue and release pointers plus occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (issue_i) tail_q <= tail_q + 1'b1;
            if (pop)     head_q <= head_q + 1'b1;
            case ({issue_i, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    // Presence flags: set on return, cleared on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            present_q <= '0;
        end else begin
            if (fill_i) present_q[fill_tag_i] <= 1'b1;
            if (pop)    present_q[head_q]     <= 1'b0;
        end
    end

    // Returned words, stored by tag.
    always_ff @(posedge clk) begin
        if (fill_i) data_q[fill_tag_i] <= fill_data_i;
    end

    // End-of-gather flags, recorded at issue.
    always_ff @(posedge clk) begin
        if (!rst_n)       last_q <= '0;
        else if (issue_i) last_q[tail_q] <= issue_last_i;
    end

    // R4: a returning word never lands on a slot still awaiting release.
    assert_fill_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_i |-> !present_q[fill_tag_i]);
    // R8: a stalled output holds its word.
    assert_hold_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
    // R9: no tag is issued beyond the buffer capacity.
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |-> !full_o);
endmodule

// File: rtl/gather_mem.sv
// Banked gather front end: hashes each request to a bank, tags it with its issue
// sequence number, and restores issue order on the response side.
// Assumes: storage loads and seed changes happen between gathers; at most one
// bank returns per cycle because all banks share one fixed latency.
module gather_mem #(
    parameter int unsigned ADDR_W = gather_pkg::GM_ADDR_W,
    parameter int unsigned DATA_W = gather_pkg::GM_DATA_W,
    parameter int unsigned NBANK  = gather_pkg::GM_NBANK,
    parameter int unsigned LAT    = gather_pkg::GM_LAT,
    parameter int unsigned BUSY   = gather_pkg::GM_BUSY,
    parameter int unsigned TAG_W  = gather_pkg::GM_TAG_W
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 cfg_seed_we,
    input  logic [ADDR_W-$clog2(NBANK)-1:0]      cfg_seed,
    input  logic                                 load_en,
    input  logic [ADDR_W-1:0]                    load_addr,
    input  logic [DATA_W-1:0]                    load_data,
    input  logic                                 req_valid,
    output logic                                 req_ready,
    input  logic [ADDR_W-1:0]                    req_addr,
    input  logic                                 req_last,
    output logic                                 rsp_valid,
    input  logic                                 rsp_ready,
    output logic [DATA_W-1:0]                    rsp_data,
    output logic                                 done
);
    localparam int unsigned BANK_W = $clog2(NBANK);
    localparam int unsigned ROW_W  = ADDR_W - BANK_W;

    logic [ROW_W-1:0]  seed_q;
    logic [BANK_W-1:0] req_bank, load_bank;
    logic [ROW_W-1:0]  req_row, load_row;
    logic [NBANK-1:0]  bank_busy;
    logic [NBANK-1:0]  ret_vec;
    logic [TAG_W-1:0]  ret_tag  [NBANK];
    logic [DATA_W-1:0] ret_data [NBANK];
    logic [TAG_W-1:0]  issue_tag;
    logic              rob_full, rob_empty, rob_last;
    logic              req_fire;
    logic              fill;
    logic [TAG_W-1:0]  fill_tag;
    logic [DATA_W-1:0] fill_data;
    logic              done_q;

    gather_hash #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_hash_req (
        .addr_i(req_addr), .seed_i(seed_q), .bank_o(req_bank), .row_o(req_row));

    gather_hash #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_hash_load (
        .addr_i(load_addr), .seed_i(seed_q), .bank_o(load_bank), .row_o(load_row));

    assign req_ready = !bank_busy[req_bank] && !rob_full;
    assign req_fire  = req_valid && req_ready;

    // Hash seed, writable only with nothing outstanding.
    always_ff @(posedge clk) begin
        if (!rst_n)                        seed_q <= '0;
        else if (cfg_seed_we && rob_empty) seed_q <= cfg_seed;
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        gather_bank #(
            .ROW_W(ROW_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .LAT(LAT), .BUSY(BUSY)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .acc_i     (req_fire && (req_bank == BANK_W'(b))),
            .row_i     (req_row),
            .tag_i     (issue_tag),
            .wr_i      (load_en && rob_empty && (load_bank == BANK_W'(b))),
            .wr_row_i  (load_row),
            .wr_data_i (load_data),
            .busy_o    (bank_busy[b]),
            .ret_o     (ret_vec[b]),
            .ret_tag_o (ret_tag[b]),
            .ret_data_o(ret_data[b])
        );
    end

    // Merge the single returning bank onto the reorder buffer fill port.
    always_comb begin
        fill      = |ret_vec;
        fill_tag  = '0;
        fill_data = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (ret_vec[b]) begin
                fill_tag  = fill_tag  | ret_tag[b];
                fill_data = fill_data | ret_data[b];
            end
        end
    end

    gather_rob #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_rob (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_i     (req_fire),
        .issue_last_i(req_last),
        .issue_tag_o (issue_tag),
        .full_o      (rob_full),
        .empty_o     (rob_empty),
        .fill_i      (fill),
        .fill_tag_i  (fill_tag),
        .fill_data_i (fill_data),
        .out_valid_o (rsp_valid),
        .out_data_o  (rsp_data),
        .out_last_o  (rob_last),
        .out_ready_i (rsp_ready)
    );

    // One-cycle completion pulse after the final response of a gather is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= rsp_valid && rsp_ready && rob_last;
    end
    assign done = done_q;

    // R4: banks never collide on the return path.
    assert_one_return_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ret_vec));
    // R10: done only follows a taken response.
    assert_done_after_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rsp_valid && rsp_ready));
    // R7: the seed cannot move while requests are outstanding.
    assert_seed_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rob_empty |=> $stable(seed_q));
endmodule

// File: tb/gather_mem_bench.sv
module gather_mem_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_seed_we = 1'b0;
    logic [5:0]  cfg_seed = '0;
    logic        load_en = 1'b0;
    logic [9:0]  load_addr = '0;
    logic [15:0] load_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [9:0]  req_addr = '0;
    logic        req_last = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [15:0] rsp_data;
    logic        done;

    gather_mem u_gather_mem (
        .clk(clk), .rst_n(rst_n), .cfg_seed_we(cfg_seed_we), .cfg_seed(cfg_seed),
        .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_last(req_last), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_data(rsp_data), .done(done));

    always #5 clk = ~clk;

    int cyc = 0;
    int n_tests = 0;
    int n_fail = 0;
    int n_iss = 0;
    int n_got = 0;
    int n_done = 0;
    int last_done_cyc = -1;
    int first_valid_cyc = -1;
    int last_waits = 0;
    int rmode = 0;
    int exp_addr [512];
    int acc_cyc  [512];
    int got_data [512];
    int got_cyc  [512];
    logic [15:0] lf = 16'hACE1;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int word_of(input int a);
        return (a * 37 + 5) & 16'hFFFF;
    endfunction

    // Response-side ready pattern, changed just after each edge.
    always @(posedge clk) begin
        #2;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        if (rmode == 0)      rsp_ready = 1'b1;
        else if (rmode == 1) rsp_ready = lf[0] | lf[3];
        else                 rsp_ready = 1'b0;
    end

    // Output monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid && first_valid_cyc < 0) first_valid_cyc = cyc;
            if (rsp_valid && rsp_ready) begin
                got_data[n_got] = int'(rsp_data);
                got_cyc[n_got]  = cyc + 1;
                n_got++;
            end
            if (done) begin
                n_done++;
                last_done_cyc = cyc;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic issue(input int a, input bit last);
        last_waits = 0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 10'(a); req_last = last;
        #1;
        while (!req_ready) begin
            last_waits++;
            @(negedge clk);
            #1;
        end
        acc_cyc[n_iss]  = cyc + 1;
        exp_addr[n_iss] = a;
        n_iss++;
        @(posedge clk);
        #1;
        req_valid = 1'b0; req_last = 1'b0;
    endtask

    task automatic drain();
        while (n_got < n_iss) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic load_all();
        for (int i = 0; i < 1024; i++) begin
            @(negedge clk);
            load_en = 1'b1; load_addr = 10'(i); load_data = 16'(word_of(i));
        end
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic set_seed(input int s);
        @(negedge clk);
        cfg_seed_we = 1'b1; cfg_seed = 6'(s);
        @(negedge clk);
        cfg_seed_we = 1'b0;
    endtask

    task automatic chk_data(input int base, input string req);
        for (int k = base; k < n_got; k++)
            chk(got_data[k] == word_of(exp_addr[k]), req, got_data[k], word_of(exp_addr[k]));
    endtask

    task automatic chk_done(input int done_before);
        chk(n_done == done_before + 1, "R10 pulse count", n_done - done_before, 1);
        chk(last_done_cyc == got_cyc[n_got-1], "R10 pulse timing", last_done_cyc, got_cyc[n_got-1]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int base;
        int db;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: idle outputs after reset
        chk(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);

        load_all();

        // R2: single request latency
        rmode = 0; base = n_got; db = n_done; first_valid_cyc = -1;
        issue(5, 1'b1);
        drain();
        chk(first_valid_cyc - acc_cyc[n_iss-1] == 17, "R2 latency",
            first_valid_cyc - acc_cyc[n_iss-1], 17);
        chk_data(base, "R2 data");
        chk_done(db);

        // R3: sixteen distinct banks stream without stalls
        base = n_got; db = n_done;
        for (int i = 0; i < 16; i++) issue(((i * 5) % 16) + 16 * i, i == 15);
        drain();
        for (int i = 1; i < 16; i++) begin
            chk(acc_cyc[base+i] - acc_cyc[base+i-1] == 1, "R3 accept spacing",
                acc_cyc[base+i] - acc_cyc[base+i-1], 1);
            chk(got_cyc[base+i] - got_cyc[base+i-1] == 1, "R3 response spacing",
                got_cyc[base+i] - got_cyc[base+i-1], 1);
        end
        chk_data(base, "R4 order stream");
        chk_done(db);

        // R4/R8: 64 scattered requests under random back-pressure
        rmode = 1; base = n_got; db = n_done;
        for (int i = 0; i < 64; i++) issue((i * 97 + 3) % 1024, i == 63);
        drain();
        chk(n_got - base == 64, "R8 no loss", n_got - base, 64);
        chk_data(base, "R8 order under back-pressure");
        chk_done(db);
        // R5: same-bank accepts in that sweep are at least 4 edges apart
        for (int k = base + 1; k < n_iss; k++)
            for (int j = base; j < k; j++)
                if ((exp_addr[k] % 16) == (exp_addr[j] % 16))
                    chk(acc_cyc[k] - acc_cyc[j] >= 4, "R5 sweep spacing",
                        acc_cyc[k] - acc_cyc[j], 4);

        // R5: direct collision with seed 0
        rmode = 0; base = n_got; db = n_done;
        issue(3, 1'b0);
        issue(19, 1'b1);
        chk(acc_cyc[n_iss-1] - acc_cyc[n_iss-2] == 4, "R5 collision gap",
            acc_cyc[n_iss-1] - acc_cyc[n_iss-2], 4);
        chk(last_waits == 3, "R5 ready low while busy", last_waits, 3);
        drain();
        chk_data(base, "R4 collision data");

        // R9: fill all 64 tags with the output stalled
        rmode = 2; base = n_got; db = n_done;
        for (int i = 0; i < 64; i++) issue(i, 1'b0);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 10'd64; req_last = 1'b1;
        for (int i = 0; i < 30; i++) begin
            #1;
            chk(req_ready == 1'b0, "R9 full blocks requests", int'(req_ready), 0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(n_got == base, "R9 nothing taken while stalled", n_got - base, 0);
        rmode = 0;
        issue(64, 1'b1);
        drain();
        chk(n_got - base == 65, "R9 all results kept", n_got - base, 65);
        chk_data(base, "R9 order after full");
        chk_done(db);

        // R7: seed and load writes while a result is outstanding are ignored
        rmode = 2; base = n_got;
        issue(7, 1'b1);
        @(negedge clk);
        cfg_seed_we = 1'b1; cfg_seed = 6'd1;
        load_en = 1'b1; load_addr = 10'd7; load_data = 16'hDEAD;
        @(negedge clk);
        cfg_seed_we = 1'b0; load_en = 1'b0;
        rmode = 0;
        drain();
        issue(0, 1'b0);
        issue(17, 1'b1);
        chk(acc_cyc[n_iss-1] - acc_cyc[n_iss-2] == 1, "R7 seed write ignored",
            acc_cyc[n_iss-1] - acc_cyc[n_iss-2], 1);
        issue(7, 1'b1);
        drain();
        chk_data(base, "R7 load write ignored");

        // R6: seed 1 makes addresses 0 and 17 share bank 0
        set_seed(1);
        load_all();
        base = n_got;
        issue(0, 1'b0);
        issue(17, 1'b1);
        chk(acc_cyc[n_iss-1] - acc_cyc[n_iss-2] == 4, "R6 seed 1 collision",
            acc_cyc[n_iss-1] - acc_cyc[n_iss-2], 4);
        issue(1, 1'b0);
        issue(16, 1'b1);
        chk(acc_cyc[n_iss-1] - acc_cyc[n_iss-2] == 4, "R6 seed 1 second pair",
            acc_cyc[n_iss-1] - acc_cyc[n_iss-2], 4);
        drain();
        chk_data(base, "R6 data seed 1");

        // R6: seed 0x20 folds addr[9] into bank bit 1
        set_seed(32);
        load_all();
        base = n_got;
        issue(2, 1'b0);
        issue(512, 1'b1);
        chk(acc_cyc[n_iss-1] - acc_cyc[n_iss-2] == 4, "R6 seed 0x20 collision",
            acc_cyc[n_iss-1] - acc_cyc[n_iss-2], 4);
        issue(3, 1'b0);
        issue(16, 1'b1);
        chk(acc_cyc[n_iss-1] - acc_cyc[n_iss-2] == 1, "R6 seed 0x20 no collision",
            acc_cyc[n_iss-1] - acc_cyc[n_iss-2], 1);
        drain();
        chk_data(base, "R6 data seed 0x20");

        // R6/R8: scattered sweep with a mixed seed and back-pressure
        set_seed(45);
        load_all();
        rmode = 1; base = n_got; db = n_done;
        for (int i = 0; i < 32; i++) issue((i * 53 + 11) % 1024, i == 31);
        drain();
        chk_data(base, "R6 sweep seed 45");
        chk_done(db);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule